// File: doc/BRIEF.md
# Instruction Word Decoder for a Small Load/Store Core

This block turns one 32-bit instruction word into the control and operand-select signals a single-issue datapath needs in the same cycle: which registers to read, which register to write, whether the write happens, what the ALU should do, whether its second operand is a register or the sign-extended 16-bit literal, whether memory is read or written, and whether the word is a conditional branch or an unconditional jump. It also hands out the sign-extended literal and the 5-bit shift count.

The decoder is pure combinational logic. It sits between the instruction fetch register and the register file, ALU, memory port and PC logic, which are not part of it. No handshake is used: the word on `instr` is decoded continuously, and every output follows it within the same cycle. Any word that is not a recognised instruction leaves the machine state untouched. An all-zero word is a true no-operation.

Top module: `rdec_top`

## Requirements
- R1: `rt_idx` always equals bits [20:16], `shamt` equals bits [10:6], and `imm_ext` is bits [15:0] sign-extended to 32 bits, so bit 15 is copied into bits [31:16].
- R2: Opcode 0 with function code 32, 34, 36, 1, 2 or 8 is a register-register operation. It sets `alu_op` to 0 (add), 1 (subtract), 2 (and), 3 (shift left), 4 (shift right) or 5 (one's complement) in that order. It writes register bits [15:11], with `alu_src_imm` = 0 and no memory, branch or jump strobe.
- R3: For shift-left, shift-right and one's-complement, `rs_idx` is 0 whatever bits [25:21] hold. For every other word, `rs_idx` equals bits [25:21].
- R4: Opcode 7 (add immediate) writes register bits [20:16] with `alu_op` = 0 and `alu_src_imm` = 1, and asserts no memory strobe.
- R5: Opcode 35 (load) asserts `mem_rd`. It writes register bits [20:16] with `alu_op` = 0 and `alu_src_imm` = 1.
- R6: Opcode 43 (store) asserts `mem_wr` with `alu_op` = 0 and `alu_src_imm` = 1. It never asserts `reg_we`, and the stored register appears on `rt_idx`.
- R7: Opcode 9 (branch if equal) asserts `branch` with `alu_op` = 1 and `alu_src_imm` = 0. It asserts no register write and no memory strobe.
- R8: Opcode 2 (jump) asserts `jump` only: no register write, no memory strobe, no branch, with `alu_op` = 0 and `alu_src_imm` = 0.
- R9: The all-zero word drives `reg_we`, `mem_rd`, `mem_wr`, `branch`, `jump`, `alu_src_imm`, `rd_idx` and `alu_op` to 0.
- R10: Any other opcode, or opcode 0 with any other function code, deasserts `reg_we`, `mem_rd`, `mem_wr`, `branch` and `jump`. It also drives `alu_op`, `alu_src_imm` and `rd_idx` to 0.
- R11: A write whose destination field is 0 is suppressed (`reg_we` = 0). `rd_idx` is 0 whenever `reg_we` is 0.
- R12: At most one of `mem_rd`, `mem_wr`, `branch` and `jump` is asserted for any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| rs_idx | output | 5 | First read register index (base register for memory and add-immediate) |
| rt_idx | output | 5 | Second read register index (store data, branch operand, shift source) |
| rd_idx | output | 5 | Destination register index, 0 when no write |
| reg_we | output | 1 | Register file write enable |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 shl, 4 shr, 5 not |
| alu_src_imm | output | 1 | 1 selects `imm_ext` as ALU B operand, 0 selects register |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| branch | output | 1 | Conditional branch-if-equal flag |
| jump | output | 1 | Unconditional jump flag |
| imm_ext | output | 32 | Sign-extended 16-bit literal or offset |
| shamt | output | 5 | Shift count |

## Verification
The hardest cases to reach are those where two rules overlap. One is a write whose destination is register 0, in each of the three places the destination can come from. The other is a one-operand operation whose bits [25:21] carry garbage that must not leak onto `rs_idx`. Random words almost never land on these. The stimulus therefore builds them directly, field by field, for every writing instruction and every one-operand function. A seeded sweep then mixes legal opcodes, illegal opcodes and unknown function codes with random fields, so the literal sign boundary (0x7FFF, 0x8000) and the suppression rules are met many times.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd7;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd9;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_SHL = 6'd1;
  localparam logic [FN_W-1:0] FN_SHR = 6'd2;
  localparam logic [FN_W-1:0] FN_NOT = 6'd8;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_SHL = 3'd3,
    ALU_SHR = 3'd4,
    ALU_NOT = 3'd5
  } alu_op_e;

  // Instruction classes after opcode/function inspection
  typedef enum logic [3:0] {
    K_NONE,
    K_REG3,    // two sources, destination in [15:11]
    K_REG1,    // single source in [20:16], destination in [15:11]
    K_ADDI,
    K_LOAD,
    K_STOR,
    K_BEQ,
    K_JMP
  } kind_e;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int RAW   = 5,
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic [XLEN-1:0]  ins,
  output logic [OPC_W-1:0] opc,
  output logic [FN_W-1:0]  fn,
  output logic [RAW-1:0]   fa,
  output logic [RAW-1:0]   fb,
  output logic [RAW-1:0]   fc,
  output logic [RAW-1:0]   sh,
  output logic [XLEN-1:0]  imm
);
  localparam int SH_LO  = FN_W;
  localparam int FC_LO  = SH_LO + RAW;
  localparam int FB_LO  = FC_LO + RAW;
  localparam int FA_LO  = FB_LO + RAW;
  localparam int OPC_LO = XLEN - OPC_W;
  localparam int EXT_W  = XLEN - IMM_W;

  assign opc = ins[XLEN-1:OPC_LO];
  assign fa  = ins[FA_LO +: RAW];
  assign fb  = ins[FB_LO +: RAW];
  assign fc  = ins[FC_LO +: RAW];
  assign sh  = ins[SH_LO +: RAW];
  assign fn  = ins[FN_W-1:0];

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm = {{EXT_W{ins[IMM_W-1]}}, ins[IMM_W-1:0]};
    end else begin : g_noext
      assign imm = ins[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/rdec_classify.sv
module rdec_classify
  import rdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  output kind_e            kind,
  output alu_op_e          op
);
  always_comb begin
    kind = K_NONE;
    op   = ALU_ADD;
    unique case (opc)
      OPC_REG: begin
        unique case (fn)
          FN_ADD:  begin kind = K_REG3; op = ALU_ADD; end
          FN_SUB:  begin kind = K_REG3; op = ALU_SUB; end
          FN_AND:  begin kind = K_REG3; op = ALU_AND; end
          FN_SHL:  begin kind = K_REG1; op = ALU_SHL; end
          FN_SHR:  begin kind = K_REG1; op = ALU_SHR; end
          FN_NOT:  begin kind = K_REG1; op = ALU_NOT; end
          default: begin kind = K_NONE; op = ALU_ADD; end
        endcase
      end
      OPC_JMP:  kind = K_JMP;
      OPC_ADDI: kind = K_ADDI;
      OPC_BEQ:  begin kind = K_BEQ; op = ALU_SUB; end
      OPC_LOAD: kind = K_LOAD;
      OPC_STOR: kind = K_STOR;
      default:  kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/rdec_ctl.sv
module rdec_ctl
  import rdec_pkg::*;
#(
  parameter int RAW = 5
) (
  input  kind_e          kind,
  input  logic [RAW-1:0] fa,
  input  logic [RAW-1:0] fb,
  input  logic [RAW-1:0] fc,
  output logic [RAW-1:0] rs_idx,
  output logic [RAW-1:0] rd_idx,
  output logic           reg_we,
  output logic           src_imm,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           branch,
  output logic           jump
);
  logic [RAW-1:0] dest;
  logic           wants_wr;

  always_comb begin
    dest     = '0;
    wants_wr = 1'b0;
    src_imm  = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    branch   = 1'b0;
    jump     = 1'b0;
    rs_idx   = fa;
    case (kind)
      K_REG3: begin dest = fc; wants_wr = 1'b1; end
      K_REG1: begin dest = fc; wants_wr = 1'b1; rs_idx = '0; end
      K_ADDI: begin dest = fb; wants_wr = 1'b1; src_imm = 1'b1; end
      K_LOAD: begin dest = fb; wants_wr = 1'b1; src_imm = 1'b1; mem_rd = 1'b1; end
      K_STOR: begin src_imm = 1'b1; mem_wr = 1'b1; end
      K_BEQ:  branch = 1'b1;
      K_JMP:  jump   = 1'b1;
      default: ;
    endcase
  end

  // register 0 is never a destination
  assign reg_we = wants_wr && (dest != '0);
  assign rd_idx = reg_we ? dest : '0;
endmodule

// File: rtl/rdec_top.sv
module rdec_top
  import rdec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int RAW   = 5
) (
  input  logic [XLEN-1:0] instr,
  output logic [RAW-1:0]  rs_idx,
  output logic [RAW-1:0]  rt_idx,
  output logic [RAW-1:0]  rd_idx,
  output logic            reg_we,
  output logic [2:0]      alu_op,
  output logic            alu_src_imm,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            branch,
  output logic            jump,
  output logic [XLEN-1:0] imm_ext,
  output logic [RAW-1:0]  shamt
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic [RAW-1:0]   fa, fb, fc;
  kind_e            kind;
  alu_op_e          op;
  logic             kind_known;

  rdec_fields #(
    .XLEN(XLEN), .IMM_W(IMM_W), .RAW(RAW), .OPC_W(OPC_W), .FN_W(FN_W)
  ) u_fields (
    .ins(instr), .opc(opc), .fn(fn), .fa(fa), .fb(fb), .fc(fc),
    .sh(shamt), .imm(imm_ext)
  );

  rdec_classify u_cls (
    .opc(opc), .fn(fn), .kind(kind), .op(op)
  );

  rdec_ctl #(.RAW(RAW)) u_ctl (
    .kind(kind), .fa(fa), .fb(fb), .fc(fc),
    .rs_idx(rs_idx), .rd_idx(rd_idx), .reg_we(reg_we),
    .src_imm(alu_src_imm), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .branch(branch), .jump(jump)
  );

  assign rt_idx     = fb;
  assign kind_known = (kind != K_NONE);
  assign alu_op     = kind_known ? op : ALU_ADD;

  always_comb begin
    a_r12_one_strobe: assert ($onehot0({mem_rd, mem_wr, branch, jump}))
      else $error("R12 more than one strobe");
    a_r11_no_zero_dest: assert (!reg_we || rd_idx != '0)
      else $error("R11 write to register 0");
    a_r9_zero_word: assert (instr != '0 ||
                            !(reg_we || mem_rd || mem_wr || branch || jump))
      else $error("R9 zero word has effect");
    a_r6_store_no_wr: assert (instr[XLEN-1 -: OPC_W] != OPC_STOR ||
                              (mem_wr && !reg_we))
      else $error("R6 store decode");
    a_r1_imm_sign: assert (imm_ext[IMM_W-1:0] == instr[IMM_W-1:0] &&
                           (imm_ext[XLEN-1:IMM_W] == '0 ||
                            imm_ext[XLEN-1:IMM_W] == '1) &&
                           imm_ext[XLEN-1] == instr[IMM_W-1])
      else $error("R1 literal extension");
    a_r10_unknown_quiet: assert (kind_known ||
                                 !(reg_we || mem_rd || mem_wr || branch || jump))
      else $error("R10 unknown word has effect");
  end
endmodule

// File: tb/rdec_top_tb_top.sv
module rdec_top_tb_top;
  localparam int EXP_W = 61;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [4:0]  rs_idx, rt_idx, rd_idx, shamt;
  logic        reg_we, alu_src_imm, mem_rd, mem_wr, branch, jump;
  logic [2:0]  alu_op;
  logic [31:0] imm_ext;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0]      w;
    logic [EXP_W-1:0] e;
    string            tag;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  rdec_top dut_i (
    .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
    .reg_we(reg_we), .alu_op(alu_op), .alu_src_imm(alu_src_imm),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch), .jump(jump),
    .imm_ext(imm_ext), .shamt(shamt)
  );

  // Expected outputs from the requirement text
  function automatic logic [EXP_W-1:0] model(input logic [31:0] w);
    logic [5:0] o, f;
    logic [4:0] rs, rd;
    logic       we, si, mr, mw, br, jp, wr;
    logic [2:0] op;
    o = w[31:26]; f = w[5:0];
    rs = w[25:21]; rd = 0; wr = 0; si = 0; mr = 0; mw = 0; br = 0; jp = 0; op = 0;
    if (o == 0) begin
      if (f == 32) begin op = 0; wr = 1; rd = w[15:11]; end
      else if (f == 34) begin op = 1; wr = 1; rd = w[15:11]; end
      else if (f == 36) begin op = 2; wr = 1; rd = w[15:11]; end
      else if (f == 1) begin op = 3; wr = 1; rd = w[15:11]; rs = 0; end
      else if (f == 2) begin op = 4; wr = 1; rd = w[15:11]; rs = 0; end
      else if (f == 8) begin op = 5; wr = 1; rd = w[15:11]; rs = 0; end
    end else if (o == 7) begin wr = 1; rd = w[20:16]; si = 1; end
    else if (o == 35) begin wr = 1; rd = w[20:16]; si = 1; mr = 1; end
    else if (o == 43) begin si = 1; mw = 1; end
    else if (o == 9) begin br = 1; op = 1; end
    else if (o == 2) jp = 1;
    we = wr && (rd != 0);
    if (!we) rd = 0;
    return {rs, w[20:16], rd, we, op, si, mr, mw, br, jp,
            {{16{w[15]}}, w[15:0]}, w[10:6]};
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    item_t it;
    @(posedge clk);
    instr <= w;
    it.w = w; it.e = model(w); it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic logic [31:0] rr(input logic [4:0] a, b, d, s,
                                     input logic [5:0] f);
    return {6'd0, a, b, d, s, f};
  endfunction

  function automatic logic [31:0] mi(input logic [5:0] o, input logic [4:0] a, b,
                                     input logic [15:0] v);
    return {o, a, b, v};
  endfunction

  // Monitor: compare away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [EXP_W-1:0] act;
        it  = sb_q.pop_front();
        act = {rs_idx, rt_idx, rd_idx, reg_we, alu_op, alu_src_imm,
               mem_rd, mem_wr, branch, jump, imm_ext, shamt};
        n_chk++;
        if (act !== it.e) begin
          n_bad++;
          $display("FAIL %s instr=%h actual=%h expected=%h", it.tag, it.w, act, it.e);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero word (R9)
    drive(32'h0, "R9 reset zero word");
    // R2 register-register functions
    drive(rr(5'd3, 5'd4, 5'd5, 5'd0, 6'd32), "R2 add");
    drive(rr(5'd31, 5'd1, 5'd9, 5'd0, 6'd34), "R2 sub");
    drive(rr(5'd7, 5'd8, 5'd30, 5'd7, 6'd36), "R2 and");
    // R3 one-operand ops with garbage in source A field
    drive(rr(5'd19, 5'd2, 5'd6, 5'd4, 6'd1), "R3 shl ignores a");
    drive(rr(5'd31, 5'd2, 5'd6, 5'd31, 6'd2), "R3 shr ignores a");
    drive(rr(5'd1, 5'd12, 5'd13, 5'd0, 6'd8), "R3 not ignores a");
    // R4 / R5 / R6 with literal sign boundaries (R1)
    drive(mi(6'd7, 5'd2, 5'd3, 16'h7fff), "R4 addi R1 max positive");
    drive(mi(6'd7, 5'd2, 5'd3, 16'h8000), "R4 addi R1 min negative");
    drive(mi(6'd35, 5'd29, 5'd17, 16'hfffc), "R5 load");
    drive(mi(6'd43, 5'd29, 5'd17, 16'h0010), "R6 store");
    drive(mi(6'd43, 5'd0, 5'd0, 16'h0000), "R6 store r0");
    drive(mi(6'd9, 5'd4, 5'd5, 16'hffff), "R7 branch");
    drive({6'd2, 26'h3ffffff}, "R8 jump");
    // R11 destination zero, each destination position
    drive(rr(5'd3, 5'd4, 5'd0, 5'd0, 6'd32), "R11 add to r0");
    drive(rr(5'd9, 5'd4, 5'd0, 5'd3, 6'd1), "R11 shl to r0");
    drive(mi(6'd7, 5'd2, 5'd0, 16'h1234), "R11 addi to r0");
    drive(mi(6'd35, 5'd2, 5'd0, 16'h8001), "R11 load to r0");
    // R10 unknown opcodes / functions
    drive(rr(5'd3, 5'd4, 5'd5, 5'd1, 6'd33), "R10 unknown function");
    drive(rr(5'd3, 5'd4, 5'd5, 5'd1, 6'd0), "R10 function zero");
    drive(mi(6'd63, 5'd1, 5'd2, 16'h8888), "R10 opcode 63");
    drive(mi(6'd8, 5'd1, 5'd2, 16'h0001), "R10 opcode 8");
    // Seeded sweep (R12 holds for every word)
    begin
      logic [5:0] ops [8] = '{6'd0, 6'd2, 6'd7, 6'd9, 6'd35, 6'd43, 6'd0, 6'd0};
      logic [5:0] fns [8] = '{6'd32, 6'd34, 6'd36, 6'd1, 6'd2, 6'd8, 6'd0, 6'd40};
      void'($urandom(32'd17));
      for (int k = 0; k < 400; k++) begin
        logic [31:0] w;
        w = $urandom;
        if (k % 4 != 3) w[31:26] = ops[$urandom % 8];
        if (w[31:26] == 0 && (k % 3 != 0)) w[5:0] = fns[$urandom % 8];
        if (k % 7 == 0) w[15:11] = 5'd0;
        if (k % 11 == 0) w[20:16] = 5'd0;
        drive(w, "R12 sweep");
      end
    end
    @(posedge clk);
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule